// File: doc/BRIEF.md
# Low-Power Counter Register Front End

This block is the register file that sits between a simple word-addressed read/write bus and a low-power counter core. Software uses it to switch the counter on and off, to request continuous running, to choose how the core counts (quadrature decoding, counting an external input, and which clock edge is active), and to load the reload limit and the match value. It also reads back the live count.

The reload and match values are treated as if they crossed into the counter's own clock domain. A write to either register is accepted only while the counter is enabled. It reaches the core a fixed `SYNC_LAT` cycles later, and at that moment a sticky completion flag rises. Software polls the flag and then acknowledges it through a write-one-to-clear register. The mode register works the other way round: it can only be changed while the counter is disabled.

Word map: 0 control, 1 mode, 2 reload, 3 match, 4 completion flags, 5 acknowledge, 6 live count. Bus reads are combinational from `bus_addr`. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `lptim_regs`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block returns to its reset state. Control, mode, match and both flags are zero, and the reload value is all ones (reads 0xFFFF at word 2 with CNT_W=16).
- R2: A write to word 2 or word 3 while the enable bit is clear is ignored. The core value and its readback stay unchanged, and no flag rises.
- R3: A write to word 2 at edge k while enabled drives `core_reload` to the written value after edge k+SYNC_LAT and sets flag bit 0 (word 4, bit 0) at that same edge. Until then the old value is kept. Clearing the enable bit afterwards does not cancel a write already in flight.
- R4: A write to word 3 behaves the same way for `core_match` and flag bit 1 (word 4, bit 1).
- R5: The flags are sticky. Writing word 5 clears each flag whose bit is 1 in the write data and leaves the other flag alone. Word 5 reads as zero, and writes to word 4 have no effect.
- R6: A write to word 0 sets the enable bit from data bit 0. The continuous-run bit (bit 1) is latched only when the same write also sets bit 0. Word 0 reads back {run, enable}. `core_enable` and `core_start` follow these bits one edge after the write.
- R7: A write to word 1 while disabled loads bit 0 into `core_quad`, bit 1 into `core_ext` and bits 3:2 into `core_edge`. Word 1 reads back those four bits. A write to word 1 while enabled is ignored.
- R8: Word 6 reads the present value of `core_count`.
- R9: Addresses 7 and above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| core_enable | output | 1 | Counter enable |
| core_start | output | 1 | Continuous-run request |
| core_quad | output | 1 | Quadrature decoding selected |
| core_ext | output | 1 | External input counting selected |
| core_edge | output | 2 | Active edge selection |
| core_reload | output | CNT_W | Applied reload limit |
| core_match | output | CNT_W | Applied match value |
| core_count | input | CNT_W | Live count from the core |

## Verification
The bench writes reload and match values while the counter is disabled. A design that ignored the enable gate would then change the core value or raise a flag. It also checks the exact edge on which an accepted write lands, which catches a latency that is off by one, and it disables the counter while a write is in flight. It acknowledges one flag at a time, so a clear that hit both flags shows up as a lost flag. It also tries to change the mode while enabled, to set the run bit without the enable bit, and to write the flag register and unmapped words. Each of these shows up as a wrong output or a wrong readback on the cycle after the write.

// File: rtl/lptim_regs.sv
module lptim_regs #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int SYNC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_enable,
  output logic              core_start,
  output logic              core_quad,
  output logic              core_ext,
  output logic [1:0]        core_edge,
  output logic [CNT_W-1:0]  core_reload,
  output logic [CNT_W-1:0]  core_match,
  input  logic [CNT_W-1:0]  core_count
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MAT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(6);

  logic [CNT_W-1:0]    rl_pend, mt_pend;
  logic [SYNC_LAT-1:0] rl_pipe, mt_pipe;
  logic [1:0]          ok_flags;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_mode = bus_wr && bus_addr == A_MODE && !core_enable;
  wire wr_rld  = bus_wr && bus_addr == A_RLD  && core_enable;
  wire wr_mat  = bus_wr && bus_addr == A_MAT  && core_enable;
  wire wr_ack  = bus_wr && bus_addr == A_ACK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_enable <= 1'b0;
      core_start  <= 1'b0;
      {core_edge, core_ext, core_quad} <= 4'd0;
      core_reload <= '1;
      core_match  <= '0;
      rl_pend     <= '0;
      mt_pend     <= '0;
      rl_pipe     <= '0;
      mt_pipe     <= '0;
      ok_flags    <= 2'b00;
    end else begin
      if (wr_ctrl) begin
        core_enable <= bus_wdata[0];
        core_start  <= bus_wdata[0] & bus_wdata[1];
      end
      if (wr_mode) {core_edge, core_ext, core_quad} <= bus_wdata[3:0];
      if (wr_rld) rl_pend <= bus_wdata[CNT_W-1:0];
      if (wr_mat) mt_pend <= bus_wdata[CNT_W-1:0];
      rl_pipe <= {rl_pipe[SYNC_LAT-2:0], wr_rld};
      mt_pipe <= {mt_pipe[SYNC_LAT-2:0], wr_mat};
      if (wr_ack) ok_flags <= ok_flags & ~bus_wdata[1:0];
      if (rl_pipe[SYNC_LAT-1]) begin
        core_reload <= rl_pend;
        ok_flags[0] <= 1'b1;
      end
      if (mt_pipe[SYNC_LAT-1]) begin
        core_match  <= mt_pend;
        ok_flags[1] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[1:0]       = {core_start, core_enable};
      A_MODE: bus_rdata[3:0]       = {core_edge, core_ext, core_quad};
      A_RLD:  bus_rdata[CNT_W-1:0] = core_reload;
      A_MAT:  bus_rdata[CNT_W-1:0] = core_match;
      A_FLG:  bus_rdata[1:0]       = ok_flags;
      A_CNT:  bus_rdata[CNT_W-1:0] = core_count;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module lptim_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              core_enable,
  input logic              core_start,
  input logic [3:0]        mode_bits,
  input logic [CNT_W-1:0]  core_reload,
  input logic [CNT_W-1:0]  core_count,
  input logic              rl_done,
  input logic [1:0]        ok_flags
);
  localparam logic [ADDR_W-1:0] C_ACK = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] C_CNT = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] C_TOP = ADDR_W'(6);

  a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> core_enable);
  a_r3_reload_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_reload) |-> ok_flags[0]);
  a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rl_done |=> ok_flags[0]);
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (core_enable && $past(core_enable)) |-> $stable(mode_bits));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_ACK && bus_wdata[0] && !rl_done) |=> !ok_flags[0]);
  a_r8_count_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_CNT) |-> bus_rdata[CNT_W-1:0] == core_count);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > C_TOP) |-> bus_rdata == '0);
endmodule

bind lptim_regs lptim_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_enable(core_enable),
  .core_start(core_start), .mode_bits({core_edge, core_ext, core_quad}),
  .core_reload(core_reload), .core_count(core_count),
  .rl_done(rl_pipe[SYNC_LAT-1]), .ok_flags(ok_flags));

// File: tb/lptim_regs_bench.sv
module lptim_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_enable, core_start, core_quad, core_ext;
  logic [1:0]  core_edge;
  logic [15:0] core_reload, core_match;
  logic [15:0] core_count = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic        m_en, m_cont;
  logic [3:0]  m_cfg;
  logic [15:0] m_rl, m_mt, rl_val, mt_val;
  logic [1:0]  m_fl;
  int          rl_due, mt_due;

  lptim_regs #(.ADDR_W(4), .DATA_W(32), .CNT_W(16), .SYNC_LAT(LAT)) u_lptim_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_enable(core_enable),
    .core_start(core_start), .core_quad(core_quad), .core_ext(core_ext),
    .core_edge(core_edge), .core_reload(core_reload), .core_match(core_match),
    .core_count(core_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cont = 0; m_cfg = 0; m_rl = 16'hFFFF; m_mt = 0; m_fl = 0;
      rl_due = -1; mt_due = -1; rl_val = 0; mt_val = 0;
    end else begin
      logic prev_en;
      cyc++;
      prev_en = m_en;
      if (bus_wr && bus_addr == 4'd5) m_fl = m_fl & ~bus_wdata[1:0];
      if (rl_due == cyc) begin m_rl = rl_val; m_fl[0] = 1'b1; end
      if (mt_due == cyc) begin m_mt = mt_val; m_fl[1] = 1'b1; end
      if (bus_wr) begin
        case (bus_addr)
          4'd0: begin m_en = bus_wdata[0]; m_cont = bus_wdata[0] & bus_wdata[1]; end
          4'd1: if (!prev_en) m_cfg = bus_wdata[3:0];
          4'd2: if (prev_en) begin rl_val = bus_wdata[15:0]; rl_due = cyc + LAT; end
          4'd3: if (prev_en) begin mt_val = bus_wdata[15:0]; mt_due = cyc + LAT; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 core_enable", {31'd0, core_enable}, {31'd0, m_en});
      chk("R6 core_start", {31'd0, core_start}, {31'd0, m_cont});
      chk("R7 mode outputs", {28'd0, core_edge, core_ext, core_quad}, {28'd0, m_cfg});
      chk("R3 core_reload", {16'd0, core_reload}, {16'd0, m_rl});
      chk("R4 core_match", {16'd0, core_match}, {16'd0, m_mt});
      case (bus_addr)
        4'd0: chk("R6 control read", bus_rdata, {30'd0, m_cont, m_en});
        4'd1: chk("R7 mode read", bus_rdata, {28'd0, m_cfg});
        4'd2: chk("R2 reload read", bus_rdata, {16'd0, m_rl});
        4'd3: chk("R2 match read", bus_rdata, {16'd0, m_mt});
        4'd4: chk("R5 flag read", bus_rdata, {30'd0, m_fl});
        4'd5: chk("R5 ack read", bus_rdata, 32'd0);
        4'd6: chk("R8 count read", bus_rdata, {16'd0, core_count});
        default: chk("R9 unmapped read", bus_rdata, 32'd0);
      endcase
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = 4'(a); bus_wr = 1'b1; bus_wdata = d; core_count = core_count + 16'd7;
    @(posedge clk); #1;
    bus_wr = 1'b0; core_count = core_count + 16'd7;
  endtask

  task automatic rd(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bus_addr = 4'(a); core_count = core_count + 16'd13;
    end
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) rd(a, 1);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(2, 1);
    @(negedge clk);
    chk("R1 reset reload", bus_rdata, 32'h0000FFFF);
    chk("R1 reset enable", {31'd0, core_enable}, 32'd0);
    sweep();
    // R2: writes while disabled
    wr(2, 32'h1234); wr(3, 32'h0055);
    rd(4, 6); rd(2, 1); rd(3, 1);
    @(negedge clk);
    chk("R2 match unchanged", {16'd0, core_match}, 32'd0);
    // R7: mode while disabled
    wr(1, 32'hD); rd(1, 2);
    // R6 run without enable
    wr(0, 32'h2); rd(0, 2);
    wr(0, 32'h3); rd(0, 2);
    wr(1, 32'h0); rd(1, 2);
    // R3 / R4
    wr(2, 32'h0040); rd(4, 5); rd(2, 1);
    wr(3, 32'h0020); rd(4, 5); rd(3, 1);
    // R5 clears one at a time
    wr(5, 32'h1); rd(4, 2);
    wr(4, 32'h3); rd(4, 2);
    wr(5, 32'h2); rd(4, 2);
    // R3 in flight while disabling
    wr(2, 32'hBEEF); wr(0, 32'h0); rd(2, 5); rd(4, 1);
    wr(3, 32'h7777); rd(3, 5);
    wr(1, 32'h6); rd(1, 2);
    wr(0, 32'h1); rd(0, 2);
    wr(3, 32'hA5A5); rd(3, 2); rd(4, 4);
    wr(5, 32'h3); rd(4, 2);
    // R9 unmapped writes
    for (int a = 7; a < 16; a++) wr(a, 32'hFFFFFFFF);
    sweep();
    rd(6, 8);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule